// File: doc/BRIEF.md
# Multi-Ratio Parallel Clock Divider

The block divides its input clock by one of six fixed integer ratios. Each ratio has its own small counter chain, and a 4-bit select word picks which chain drives the single divided-clock output through a 16-way multiplexer. Every chain has a fixed high-time pattern, so several ratios are deliberately not at 50% duty. A downstream edge-sensitive phase comparator only needs one rising edge every N input cycles.

Only the chain named by the registered select is allowed to count. All other chains are held at their reset count, so they draw no switching power. When the select moves, the newly chosen chain restarts from the beginning of its high phase. The output is a flip-flop, so a switch can never produce a pulse shorter than one input period. A 6-bit one-hot status shows which chain is currently running.

Top module: `clkdiv_multi`

## Requirements
- R1: Select codes map to ratios as follows: 0 gives divide by 2, 1 gives 3, 2 gives 5, 3 gives 7, 4 gives 8 and 5 gives 13. While the select is held steady, `div_clk` rises exactly once every N input cycles.
- R2: Within each period, `div_clk` is high for the first H cycles and low for the remaining N−H cycles. H is 1 for divide by 2, 2 for 3, 2 for 5, 6 for 7, 4 for 8 and 12 for 13.
- R3: Select codes 6 to 15 enable no chain, so `chain_en` is zero. `div_clk` is low from the second rising edge after such a code is applied, for as long as the code is held.
- R4: `chain_en` has at most one bit set. Bit i is set exactly when the select sampled at the previous rising edge was i (0 to 5) and the block is out of reset.
- R5: A chain that is not selected is held at its start count. Every time a chain is selected, including a return to a chain that was abandoned mid-period, it restarts with a full high phase.
- R6: If a new select is sampled at edge k, `chain_en` changes after edge k. From edge k+1 onward, `div_clk` follows the new chain's pattern starting at its high phase. No high or low pulse on `div_clk` is shorter than one input cycle.
- R7: While `rst` is sampled high, `chain_en` is zero and `div_clk` is low after that edge. After reset is released, the first high phase starts at the second rising edge, with the same timing as a select change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 4 | Ratio select code |
| div_clk | output | 1 | Divided clock, registered |
| chain_en | output | 6 | One-hot status of the running chain |

## Verification
A select change and the restart of the chosen chain fall in the same cycle. In that cycle the departing chain is still driving the output register while the arriving chain leaves its held count. The bench provokes this by switching the select mid-period, for example from divide by 7 to divide by 3 and then back to 7. Each switch is judged by sampling `div_clk` on every cycle from the second edge after the switch and comparing it with a full high phase followed by the exact period. A reset release with a valid code already applied is judged in the same way.

// File: rtl/clkdiv_multi.sv
module clkdiv_multi #(
  parameter int SEL_W      = 4,
  parameter int NUM_CHAINS = 6,
  parameter int CNT_W      = 4,
  parameter logic [NUM_CHAINS*CNT_W-1:0] RATIOS = {4'd13, 4'd8, 4'd7, 4'd5, 4'd3, 4'd2},
  parameter logic [NUM_CHAINS*CNT_W-1:0] HIGHS  = {4'd12, 4'd4, 4'd6, 4'd2, 4'd2, 4'd1}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SEL_W-1:0]      sel,
  output logic                  div_clk,
  output logic [NUM_CHAINS-1:0] chain_en
);
  localparam int MUX_N = 2 ** SEL_W;

  logic [SEL_W-1:0]      sel_q;
  logic                  run_q;
  logic [NUM_CHAINS-1:0] hi;
  logic [MUX_N-1:0]      mux_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      run_q <= 1'b0;
    end else begin
      sel_q <= sel;
      run_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_chain
    localparam logic [CNT_W-1:0] N = RATIOS[g*CNT_W +: CNT_W];
    localparam logic [CNT_W-1:0] H = HIGHS[g*CNT_W +: CNT_W];
    logic [CNT_W-1:0] cnt;

    assign chain_en[g] = run_q && (sel_q == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (rst || !chain_en[g]) cnt <= '0;
      else if (cnt == N - 1'b1) cnt <= '0;
      else cnt <= cnt + 1'b1;
    end

    assign hi[g] = chain_en[g] && (cnt < H);
  end

  assign mux_in = {{(MUX_N-NUM_CHAINS){1'b0}}, hi};

  always_ff @(posedge clk) begin
    if (rst) div_clk <= 1'b0;
    else     div_clk <= mux_in[sel_q];
  end
endmodule

module clkdiv_multi_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] sel,
  input logic       div_clk,
  input logic [5:0] chain_en
);
  function automatic logic [5:0] exp_en(input logic [3:0] s);
    exp_en = (s < 4'd6) ? (6'd1 << s) : 6'd0;
  endfunction

  // R4
  en_onehot_chk: assert property (@(posedge clk) $onehot0(chain_en));

  // R4
  en_decode_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> chain_en == exp_en($past(sel)));

  // R3
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (chain_en == 6'd0) |=> !div_clk);

  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!div_clk && chain_en == 6'd0));
endmodule

bind clkdiv_multi clkdiv_multi_chk i_chk (.*);

// File: tb/test_clkdiv_multi.sv
module test_clkdiv_multi;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] sel = 4'd0;
  logic       div_clk;
  logic [5:0] chain_en;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clkdiv_multi i_clkdiv_multi (.clk(clk), .rst(rst), .sel(sel), .div_clk(div_clk), .chain_en(chain_en));

  function automatic int ratio_of(input int c);
    case (c)
      0: return 2; 1: return 3; 2: return 5; 3: return 7; 4: return 8; 5: return 13;
      default: return 0;
    endcase
  endfunction

  function automatic int high_of(input int c);
    case (c)
      0: return 1; 1: return 2; 2: return 2; 3: return 6; 4: return 4; 5: return 12;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_pattern(input int c, input int periods, input string req);
    int n = ratio_of(c);
    int h = high_of(c);
    for (int j = 0; j < n * periods; j++) begin
      @(negedge clk);
      check(div_clk == ((j % n) < h), req, div_clk, int'((j % n) < h));
    end
  endtask

  task automatic select_ratio(input int c, input int periods);
    @(negedge clk);
    sel = 4'(c);
    @(negedge clk);
    check(chain_en == (6'd1 << c), "R4", chain_en, 6'd1 << c);
    expect_pattern(c, periods, "R1 R2 R6");
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(div_clk == 1'b0, "R7", div_clk, 0);
    check(chain_en == 6'd0, "R7", chain_en, 0);
    sel = 4'd3;
    rst = 1'b0;
    @(negedge clk);
    check(chain_en == 6'b001000, "R7", chain_en, 6'b001000);
    check(div_clk == 1'b0, "R7", div_clk, 0);
    expect_pattern(3, 2, "R7");
  endtask

  task automatic test_all_ratios();
    for (int c = 0; c < 6; c++) select_ratio(c, 3);
  endtask

  task automatic test_invalid();
    @(negedge clk);
    sel = 4'd9;
    @(negedge clk);
    check(chain_en == 6'd0, "R3", chain_en, 0);
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      check(div_clk == 1'b0, "R3", div_clk, 0);
    end
    sel = 4'd15;
    @(negedge clk);
    @(negedge clk);
    check(div_clk == 1'b0 && chain_en == 6'd0, "R3", {chain_en, div_clk}, 0);
  endtask

  task automatic test_midswitch();
    @(negedge clk);
    sel = 4'd3;
    repeat (4) @(negedge clk);
    select_ratio(1, 2);
    @(negedge clk);
    sel = 4'd3;
    @(negedge clk);
    check(chain_en == 6'b001000, "R5", chain_en, 6'b001000);
    expect_pattern(3, 2, "R5");
    @(negedge clk);
    sel = 4'd5;
    repeat (7) @(negedge clk);
    select_ratio(0, 3);
    select_ratio(5, 2);
  endtask

  task automatic test_reset_midrun();
    @(negedge clk);
    sel = 4'd4;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(div_clk == 1'b0 && chain_en == 6'd0, "R7", {chain_en, div_clk}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(chain_en == 6'b010000, "R7", chain_en, 6'b010000);
    expect_pattern(4, 2, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_all_ratios();
    test_invalid();
    test_midswitch();
    test_reset_midrun();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule